// File: doc/BRIEF.md
# Bank-Aware DRAM Request Scheduler

This block sits between a stream of memory requests and the DRAM command path. It decides, one memory cycle at a time, which pending request may go to the memory next. Each request carries an address and a direction flag. It enters a small input queue and then moves into a queue owned by the bank that the address decodes to. Every cycle the block scans the banks in round-robin order, starting at a rotating pointer. It issues the first head-of-queue request that every timing rule allows. The rules cover per-bank recovery time, shared data-bus occupancy, read-to-write and rank-switch turnarounds, a starvation guard, and a per-rank inhibit supplied by an external activation-window tracker.

The request port follows valid/ready rules. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` depends only on the fill of the input queue, never on `req_valid`. A sender that sees `req_ready` low holds its request stable until it is taken. The issue and response outputs are one-cycle strobes with no back-pressure: the command path must accept every issue. A read produces a response strobe a fixed number of cycles after its issue. A write produces none.

Top module: `dram_bank_sched`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `req_ready` is 1 and `issue_valid` and `rsp_valid` are 0.
- R2: A request is accepted on an edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 exactly when the input queue holds IQ_DEPTH requests. At each edge the oldest input-queue entry moves into its bank queue if that queue, counting this edge's issue, has room. Later entries wait behind it in strict order.
- R3: The bank index is `req_addr[BANK_LSB +: log2(NUM_BANKS)]`. The rank is that index divided by BANKS_PER_RANK. `issue_bank`, `issue_rank` and `issue_addr` report exactly these values for the issued request. `issue_write` is 1 for a write and 0 for a read.
- R4: A bank that issued at edge k cannot issue again before edge k+BANK_BUSY+1.
- R5: A free-running age counter counts 0 to 4·BANK_BUSY−1 and wraps. At the wrap edge, every bank whose queue is non-empty afterwards is marked old. An issue from a bank clears its mark. While the counter is above 2·BANK_BUSY, only marked banks may issue.
- R6: After any issue at edge k, nothing issues before edge k+BUS_BUSY+1. After a read issued at edge k, no write issues before edge k+BUS_BUSY+RD2WR_DLY+1.
- R7: After a write issued at edge k, both a following write and a following read to another rank may issue from edge k+BUS_BUSY+1 on.
- R8: After a read issued at edge k, a read to a different rank may not issue before edge k+BUS_BUSY+RANK_SW_DLY+1. A read to the same rank waits only for the bus rule of R6.
- R9: No request to rank r issues at an edge where `act_block[r]` is 1.
- R10: The scan pointer starts at bank 0 and advances by one bank every cycle, wrapping after NUM_BANKS−1. The block issues the first eligible bank at or after the pointer, in ascending order with wrap. At most one request issues per edge.
- R11: `rsp_valid` is 1 exactly RSP_LAT cycles after a cycle in which `issue_valid` was 1 with `issue_write` 0. `rsp_bank` equals that read's bank. Writes never cause `rsp_valid`.
- R12: The issue outputs are registered. A request accepted at edge k can issue at edge k+2 at the earliest, and `issue_valid` is high for the one cycle after its issue edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Input queue can take a request |
| req_addr | input | ADDR_W | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| act_block | input | NUM_RANKS | Per-rank issue inhibit from the activation-window tracker |
| issue_valid | output | 1 | One request issued last edge |
| issue_bank | output | log2(NUM_BANKS) | Bank of the issued request |
| issue_rank | output | log2(NUM_RANKS) | Rank of the issued request |
| issue_write | output | 1 | Direction of the issued request |
| issue_addr | output | ADDR_W | Address of the issued request |
| rsp_valid | output | 1 | Read response due |
| rsp_bank | output | log2(NUM_BANKS) | Bank of the responding read |

## Verification
Issue decisions take effect at a clock edge and show on the issue outputs during the following cycle. A read's response strobe follows that visible issue cycle by RSP_LAT cycles. `req_ready` reflects the input-queue fill registered at the last edge. The bench steps a reference model on each rising edge with the same inputs the design sees. It compares every output at the falling edge after that, so each expected value is read in the cycle it becomes due. Directed sequences line up bank, bus, turnaround, inhibit and queue-full timing. Long random runs cover the age window and round-robin order.

// File: rtl/dram_sched_pkg.sv
package dram_sched_pkg;
  typedef enum logic {
    DIR_READ  = 1'b0,
    DIR_WRITE = 1'b1
  } dir_e;

  function automatic int ceil_log2(input int v);
    int r;
    r = 0;
    while ((1 << r) < v) r++;
    return (r < 1) ? 1 : r;
  endfunction
endpackage

// File: rtl/sched_fifo.sv
module sched_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  assign head = mem[rp];
endmodule

// File: rtl/sched_bus_timer.sv
module sched_bus_timer #(
  parameter int RANK_W      = 1,
  parameter int BUS_BUSY    = 2,
  parameter int RD2WR_DLY   = 2,
  parameter int RANK_SW_DLY = 1,
  localparam int MAXV = BUS_BUSY + ((RD2WR_DLY > RANK_SW_DLY) ? RD2WR_DLY : RANK_SW_DLY),
  localparam int CW   = $clog2(MAXV + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              fire_write,
  input  logic [RANK_W-1:0] fire_rank,
  output logic              bus_free,
  output logic              write_free,
  output logic              rank_sw_free,
  output logic [RANK_W-1:0] last_rank
);
  logic [CW-1:0] bus_cnt, wr_cnt, rs_cnt;

  function automatic logic [CW-1:0] dec(input logic [CW-1:0] v);
    return (v != '0) ? v - 1'b1 : v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_cnt   <= '0;
      wr_cnt    <= '0;
      rs_cnt    <= '0;
      last_rank <= '0;
    end else if (fire) begin
      bus_cnt   <= CW'(BUS_BUSY);
      wr_cnt    <= fire_write ? CW'(BUS_BUSY) : CW'(BUS_BUSY + RD2WR_DLY);
      rs_cnt    <= fire_write ? CW'(BUS_BUSY) : CW'(BUS_BUSY + RANK_SW_DLY);
      last_rank <= fire_rank;
    end else begin
      bus_cnt <= dec(bus_cnt);
      wr_cnt  <= dec(wr_cnt);
      rs_cnt  <= dec(rs_cnt);
    end
  end

  assign bus_free     = (bus_cnt == '0);
  assign write_free   = (wr_cnt == '0);
  assign rank_sw_free = (rs_cnt == '0);
endmodule

// File: rtl/sched_rr_pick.sv
module sched_rr_pick #(
  parameter int N  = 4,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  elig,
  input  logic [IW-1:0] start,
  output logic          grant,
  output logic [IW-1:0] grant_idx
);
  always_comb begin
    int b;
    grant     = 1'b0;
    grant_idx = '0;
    for (int i = 0; i < N; i++) begin
      b = (int'(start) + i) % N;
      if (!grant && elig[b]) begin
        grant     = 1'b1;
        grant_idx = IW'(b);
      end
    end
  end
endmodule

// File: rtl/dram_bank_sched.sv
module dram_bank_sched
  import dram_sched_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int NUM_BANKS      = 4,
  parameter int BANKS_PER_RANK = 2,
  parameter int BANK_LSB       = 6,
  parameter int BANK_DEPTH     = 2,
  parameter int IQ_DEPTH       = 4,
  parameter int BANK_BUSY      = 5,
  parameter int BUS_BUSY       = 2,
  parameter int RD2WR_DLY      = 2,
  parameter int RANK_SW_DLY    = 1,
  parameter int RSP_LAT        = 4,
  localparam int BANK_W    = $clog2(NUM_BANKS),
  localparam int NUM_RANKS = NUM_BANKS / BANKS_PER_RANK,
  localparam int RANK_W    = ceil_log2(NUM_RANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_write,
  input  logic [NUM_RANKS-1:0] act_block,
  output logic                 issue_valid,
  output logic [BANK_W-1:0]    issue_bank,
  output logic [RANK_W-1:0]    issue_rank,
  output logic                 issue_write,
  output logic [ADDR_W-1:0]    issue_addr,
  output logic                 rsp_valid,
  output logic [BANK_W-1:0]    rsp_bank
);
  localparam int EW         = ADDR_W + 1;
  localparam int IQ_CW      = $clog2(IQ_DEPTH + 1);
  localparam int BQ_CW      = $clog2(BANK_DEPTH + 1);
  localparam int BB_W       = $clog2(BANK_BUSY + 1);
  localparam int AGE_PERIOD = 4 * BANK_BUSY;
  localparam int AGE_W      = $clog2(AGE_PERIOD);

  // input queue
  logic [EW-1:0]    iq_head;
  logic [IQ_CW-1:0] iq_cnt;
  logic             iq_move;
  logic [BANK_W-1:0] iq_bank;

  assign req_ready = (iq_cnt < IQ_CDEPTH());
  function automatic logic [IQ_CW-1:0] IQ_CDEPTH();
    return IQ_CW'(IQ_DEPTH);
  endfunction
  assign iq_bank = iq_head[BANK_LSB +: BANK_W];

  sched_fifo #(.W(EW), .DEPTH(IQ_DEPTH)) u_iq (
    .clk(clk), .rst_n(rst_n),
    .push(req_valid && req_ready), .push_data({req_write, req_addr}),
    .pop(iq_move), .head(iq_head), .count(iq_cnt)
  );

  // shared timing state
  logic [BANK_W-1:0] rr_ptr;
  logic [AGE_W-1:0]  age;
  logic              age_wrap, age_strict;
  logic              bus_free, write_free, rank_sw_free;
  logic [RANK_W-1:0] last_rank;

  assign age_wrap   = (age == AGE_W'(AGE_PERIOD - 1));
  assign age_strict = (age > AGE_W'(2 * BANK_BUSY));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_ptr <= '0;
      age    <= '0;
    end else begin
      rr_ptr <= (rr_ptr == BANK_W'(NUM_BANKS - 1)) ? '0 : rr_ptr + 1'b1;
      age    <= age_wrap ? '0 : age + 1'b1;
    end
  end

  // per-bank queues and eligibility
  logic [NUM_BANKS-1:0] elig, bq_push, bq_pop;
  logic [EW-1:0]        bq_head [NUM_BANKS];
  logic                 pick_valid;
  logic [BANK_W-1:0]    pick_idx;
  logic [EW-1:0]        pick_entry;
  logic [RANK_W-1:0]    pick_rank;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [RANK_W-1:0] RK = RANK_W'(b / BANKS_PER_RANK);
    logic [BQ_CW-1:0] cnt;
    logic [BB_W-1:0]  busy;
    logic             old_mark, is_wr, room;

    sched_fifo #(.W(EW), .DEPTH(BANK_DEPTH)) u_q (
      .clk(clk), .rst_n(rst_n),
      .push(bq_push[b]), .push_data(iq_head),
      .pop(bq_pop[b]), .head(bq_head[b]), .count(cnt)
    );

    assign bq_pop[b]  = pick_valid && (pick_idx == BANK_W'(b));
    assign room       = (cnt < BQ_CW'(BANK_DEPTH)) || bq_pop[b];
    assign bq_push[b] = (iq_cnt != '0) && (iq_bank == BANK_W'(b)) && room;
    assign is_wr      = bq_head[b][ADDR_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy     <= '0;
        old_mark <= 1'b0;
      end else begin
        if (bq_pop[b])         busy <= BB_W'(BANK_BUSY);
        else if (busy != '0)   busy <= busy - 1'b1;
        if (age_wrap)          old_mark <= ((cnt + BQ_CW'(bq_push[b]) - BQ_CW'(bq_pop[b])) != '0);
        else if (bq_pop[b])    old_mark <= 1'b0;
      end
    end

    assign elig[b] = (cnt != '0) && (busy == '0) && (!age_strict || old_mark) &&
                     bus_free && !act_block[RK] &&
                     (is_wr ? write_free : ((RK == last_rank) || rank_sw_free));
  end

  assign iq_move = |bq_push;

  sched_rr_pick #(.N(NUM_BANKS)) u_pick (
    .elig(elig), .start(rr_ptr), .grant(pick_valid), .grant_idx(pick_idx)
  );

  assign pick_entry = bq_head[pick_idx];
  assign pick_rank  = RANK_W'(int'(pick_idx) / BANKS_PER_RANK);

  sched_bus_timer #(
    .RANK_W(RANK_W), .BUS_BUSY(BUS_BUSY), .RD2WR_DLY(RD2WR_DLY), .RANK_SW_DLY(RANK_SW_DLY)
  ) u_bus (
    .clk(clk), .rst_n(rst_n),
    .fire(pick_valid), .fire_write(pick_entry[ADDR_W]), .fire_rank(pick_rank),
    .bus_free(bus_free), .write_free(write_free), .rank_sw_free(rank_sw_free),
    .last_rank(last_rank)
  );

  // registered issue strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issue_valid <= 1'b0;
      issue_bank  <= '0;
      issue_rank  <= '0;
      issue_write <= DIR_READ;
      issue_addr  <= '0;
    end else begin
      issue_valid <= pick_valid;
      if (pick_valid) begin
        issue_bank  <= pick_idx;
        issue_rank  <= pick_rank;
        issue_write <= pick_entry[ADDR_W];
        issue_addr  <= pick_entry[ADDR_W-1:0];
      end
    end
  end

  // read response delay line
  logic [RSP_LAT-1:0] rv_pipe;
  logic [BANK_W-1:0]  rb_pipe [RSP_LAT];

  for (genvar s = 0; s < RSP_LAT; s++) begin : g_rsp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rv_pipe[s] <= 1'b0;
        rb_pipe[s] <= '0;
      end else if (s == 0) begin
        rv_pipe[s] <= issue_valid && (issue_write == DIR_READ);
        rb_pipe[s] <= issue_bank;
      end else begin
        rv_pipe[s] <= rv_pipe[(s == 0) ? 0 : s - 1];
        rb_pipe[s] <= rb_pipe[(s == 0) ? 0 : s - 1];
      end
    end
  end

  assign rsp_valid = rv_pipe[RSP_LAT-1];
  assign rsp_bank  = rb_pipe[RSP_LAT-1];
endmodule

// File: rtl/dram_bank_sched_chk.sv
module dram_bank_sched_chk #(
  parameter int NUM_BANKS = 4,
  parameter int NUM_RANKS = 2,
  parameter int IQ_CW     = 3,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_ready,
  input logic [NUM_RANKS-1:0] act_block,
  input logic                 issue_valid,
  input logic [BANK_W-1:0]    issue_bank,
  input logic [RANK_W-1:0]    issue_rank,
  input logic [IQ_CW-1:0]     iq_cnt,
  input logic [BANK_W-1:0]    rr_ptr
);
  // R2: nothing enters the input queue while it refuses requests
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> (iq_cnt <= $past(iq_cnt)));

  // R4: a bank never issues on two adjacent edges
  a_r4_bank_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> !(issue_valid && (issue_bank == $past(issue_bank))));

  // R6: the data bus is held for at least one cycle after any issue
  a_r6_bus_gap: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> !issue_valid);

  // R9: an inhibited rank is never issued
  a_r9_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (($past(act_block) & (NUM_RANKS'(1) << issue_rank)) == '0));

  // R10: the scan pointer steps by one bank per cycle with wrap
  a_r10_rr_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rr_ptr == (($past(rr_ptr) == BANK_W'(NUM_BANKS - 1)) ? '0 : $past(rr_ptr) + 1'b1)));
endmodule

bind dram_bank_sched dram_bank_sched_chk #(
  .NUM_BANKS(NUM_BANKS), .NUM_RANKS(NUM_RANKS), .IQ_CW(IQ_CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .act_block(act_block),
  .issue_valid(issue_valid), .issue_bank(issue_bank), .issue_rank(issue_rank),
  .iq_cnt(iq_cnt), .rr_ptr(rr_ptr)
);

// File: tb/dram_bank_sched_bench.sv
module dram_bank_sched_bench;
  localparam int AW = 16, NB = 4, BPR = 2, BL = 6, BD = 2, IQD = 4;
  localparam int BB = 5, BUS = 2, R2W = 2, RSW = 1, LAT = 4;
  localparam int NR = NB / BPR, BW = 2, RW = 1, AP = 4 * BB;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [NR-1:0] act_block = '0;
  logic req_ready, issue_valid, issue_write, rsp_valid;
  logic [BW-1:0] issue_bank, rsp_bank;
  logic [RW-1:0] issue_rank;
  logic [AW-1:0] issue_addr;

  always #4 clk = ~clk;

  dram_bank_sched u_dram_bank_sched (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .act_block(act_block),
    .issue_valid(issue_valid), .issue_bank(issue_bank), .issue_rank(issue_rank),
    .issue_write(issue_write), .issue_addr(issue_addr),
    .rsp_valid(rsp_valid), .rsp_bank(rsp_bank)
  );

  int n_chk = 0, n_fail = 0;
  string cur_tag = "R1";
  bit done = 0;

  // reference model state
  int iq_a [IQD]; bit iq_w [IQD]; int iqn = 0;
  int bq_a [NB][BD]; bit bq_w [NB][BD]; int bqn [NB];
  int busy [NB]; bit old_m [NB];
  int bus_c = 0, wr_c = 0, rs_c = 0, last_rk = 0, ptr = 0, age = 0;
  bit m_iv = 0, m_iw = 0; int m_ib = 0, m_ir = 0, m_ia = 0;
  bit rv [LAT]; int rb [LAT];
  bit acc_last = 0;

  function automatic int bank_of(input int a); return (a >> BL) % NB; endfunction
  function automatic int rank_of(input int b); return b / BPR; endfunction
  function automatic int mk_addr(input int b, input int hi, input int lo);
    return ((hi << (BL + BW)) | (b << BL) | (lo % (1 << BL))) & ((1 << AW) - 1);
  endfunction

  function automatic bit eligible(input int b);
    bit w;
    if (bqn[b] == 0 || busy[b] != 0 || bus_c != 0) return 0;
    if (age > 2 * BB && !old_m[b]) return 0;
    if (act_block[rank_of(b)]) return 0;
    w = bq_w[b][0];
    if (w) return wr_c == 0;
    return (rank_of(b) == last_rk) || (rs_c == 0);
  endfunction

  task automatic model_step();
    int pick; bit acc; int hb;
    pick = -1;
    acc = req_valid && (iqn < IQD);
    for (int i = 0; i < NB; i++) begin
      int b; b = (ptr + i) % NB;
      if (pick < 0 && eligible(b)) pick = b;
    end
    for (int k = LAT - 1; k > 0; k--) begin rv[k] = rv[k-1]; rb[k] = rb[k-1]; end
    rv[0] = m_iv && !m_iw; rb[0] = m_ib;
    m_iv = (pick >= 0);
    for (int b = 0; b < NB; b++) if (busy[b] > 0) busy[b]--;
    if (pick >= 0) begin
      m_ib = pick; m_ir = rank_of(pick); m_iw = bq_w[pick][0]; m_ia = bq_a[pick][0];
      busy[pick] = BB;
      bus_c = BUS; wr_c = m_iw ? BUS : BUS + R2W; rs_c = m_iw ? BUS : BUS + RSW;
      last_rk = m_ir;
      for (int j = 0; j < BD - 1; j++) begin bq_a[pick][j] = bq_a[pick][j+1]; bq_w[pick][j] = bq_w[pick][j+1]; end
      bqn[pick]--;
    end else begin
      if (bus_c > 0) bus_c--;
      if (wr_c > 0) wr_c--;
      if (rs_c > 0) rs_c--;
    end
    if (iqn > 0) begin
      hb = bank_of(iq_a[0]);
      if (bqn[hb] < BD) begin
        bq_a[hb][bqn[hb]] = iq_a[0]; bq_w[hb][bqn[hb]] = iq_w[0]; bqn[hb]++;
        for (int j = 0; j < IQD - 1; j++) begin iq_a[j] = iq_a[j+1]; iq_w[j] = iq_w[j+1]; end
        iqn--;
      end
    end
    if (acc) begin iq_a[iqn] = int'(req_addr); iq_w[iqn] = req_write; iqn++; end
    acc_last = acc;
    for (int b = 0; b < NB; b++) begin
      if (age == AP - 1) old_m[b] = (bqn[b] != 0);
      else if (b == pick) old_m[b] = 0;
    end
    age = (age + 1) % AP;
    ptr = (ptr + 1) % NB;
  endtask

  always @(posedge clk) if (rst_n && !done) model_step();

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", cur_tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(req_ready == (iqn < IQD), "req_ready", req_ready, iqn < IQD);
      chk(issue_valid == m_iv, "issue_valid", issue_valid, m_iv);
      if (m_iv && issue_valid) begin
        chk(issue_bank == m_ib, "issue_bank", issue_bank, m_ib);
        chk(issue_rank == m_ir, "issue_rank", issue_rank, m_ir);
        chk(issue_write == m_iw, "issue_write", issue_write, m_iw);
        chk(int'(issue_addr) == m_ia, "issue_addr", issue_addr, m_ia);
      end
      chk(rsp_valid == rv[LAT-1], "rsp_valid", rsp_valid, rv[LAT-1]);
      if (rv[LAT-1] && rsp_valid) chk(rsp_bank == rb[LAT-1], "rsp_bank", rsp_bank, rb[LAT-1]);
    end
  end

  // called at a negedge; returns at the negedge after acceptance
  task automatic push_req(input int a, input bit w);
    req_valid = 1; req_addr = AW'(a); req_write = w;
    do @(negedge clk); while (!acc_last);
  endtask

  task automatic idle(input int n);
    req_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic run_random(input int cycles, input int pv, input int pw, input int pb);
    repeat (cycles) begin
      if (!req_valid || acc_last) begin
        req_valid = ($urandom_range(99) < pv);
        req_addr  = AW'($urandom);
        req_write = ($urandom_range(99) < pw);
      end
      for (int r = 0; r < NR; r++) act_block[r] = ($urandom_range(99) < pb);
      @(negedge clk);
    end
    act_block = '0;
    idle(40);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int b = 0; b < NB; b++) begin bqn[b] = 0; busy[b] = 0; old_m[b] = 0; end
    for (int k = 0; k < LAT; k++) begin rv[k] = 0; rb[k] = 0; end
    repeat (3) @(negedge clk);
    // R1: outputs while reset is held
    chk(req_ready == 1 && issue_valid == 0 && rsp_valid == 0, "reset outputs",
        {req_ready, issue_valid, rsp_valid}, 3'b100);
    rst_n = 1;
    @(negedge clk);
    // R1: first cycle after release
    chk(req_ready == 1 && issue_valid == 0 && rsp_valid == 0, "post-reset outputs",
        {req_ready, issue_valid, rsp_valid}, 3'b100);

    cur_tag = "R3 R12";
    push_req(mk_addr(2, 5, 3), 0);
    push_req(mk_addr(1, 9, 60), 1);
    push_req(mk_addr(3, 0, 1), 0);
    idle(30);

    cur_tag = "R4";
    push_req(mk_addr(1, 1, 0), 0);
    push_req(mk_addr(1, 2, 0), 0);
    push_req(mk_addr(1, 3, 0), 1);
    idle(30);

    cur_tag = "R6";
    push_req(mk_addr(0, 1, 0), 0);
    push_req(mk_addr(2, 1, 0), 1);
    push_req(mk_addr(1, 1, 0), 0);
    idle(30);

    cur_tag = "R7";
    push_req(mk_addr(0, 4, 0), 1);
    push_req(mk_addr(3, 4, 0), 0);
    push_req(mk_addr(1, 4, 0), 1);
    idle(30);

    cur_tag = "R8";
    push_req(mk_addr(0, 6, 0), 0);
    push_req(mk_addr(2, 6, 0), 0);
    push_req(mk_addr(1, 6, 0), 0);
    push_req(mk_addr(3, 6, 0), 0);
    idle(40);

    cur_tag = "R9";
    act_block = 2'b01;
    push_req(mk_addr(0, 7, 0), 0);
    push_req(mk_addr(1, 7, 0), 1);
    push_req(mk_addr(2, 7, 0), 0);
    idle(20);
    act_block = 2'b00;
    idle(30);

    cur_tag = "R2";
    act_block = 2'b11;
    for (int i = 0; i < 8; i++) begin
      req_valid = 1; req_addr = AW'(mk_addr(0, i, i)); req_write = i[0];
      @(negedge clk);
    end
    // R2: bank 0 queue full and input queue full, so intake stops
    chk(req_ready == 0, "ready low when input queue full", req_ready, 0);
    req_valid = 0;
    act_block = 2'b00;
    idle(80);

    cur_tag = "R5 R10 R11";
    run_random(3000, 70, 40, 10);
    cur_tag = "R2 R4 R6 R8";
    run_random(2000, 90, 50, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog R12 actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule